// File: doc/BRIEF.md
# Switchable Binary/Gray Modal Counter

A small synchronous counter that moves one step on every rising clock edge. A mode input is sampled at each edge and picks the sequence for that step. In one mode the count climbs in natural binary order. In the other it walks the reflected Gray order. The mode may change on any cycle. The counter never re-encodes its state when the mode changes. It takes the present code as it stands and moves to that code's successor in whichever sequence the mode picks at that edge.

A synchronous, active-high reset returns the count to zero and wins over counting in the same cycle. The count port is the state register itself, so no decode stage sits between the state and the output. The width is a parameter whose default is 3 bits. All requirements below are written for that default.

Top module: `modal_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge, `count` is 000 after that edge, whatever the value of `mode_gray`. After the first reset edge the count starts at 000.
- R2: When `rst` is 0 and `mode_gray` is 0 at an edge, `count` takes the next value of the order 000,001,010,011,100,101,110,111. The value 111 wraps to 000.
- R3: When `rst` is 0 and `mode_gray` is 1 at an edge, `count` takes the next value of the order 000,001,011,010,110,111,101,100. The value 100 wraps to 000.
- R4: The mode is read at every edge. The successor is looked up from the present code in the sequence chosen at that edge, with no re-encoding. For example, 010 in Gray mode goes to 110, 110 in binary mode goes to 111, and 011 in Gray mode goes to 010.
- R5: Every step taken in Gray mode changes exactly one bit of `count`.
- R6: Starting from 000 with `mode_gray` driven 0,0,1,1 on four edges, `count` reads 001, 010, 110, 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_gray | input | 1 | 0 selects binary order, 1 selects Gray order for this step |
| count | output | WIDTH (3) | Current counter code, driven straight from the state register |

## Verification
The checker tests four rules on every cycle:

- The clear that follows a reset edge.
- The binary increment with its wrap.
- The single-bit change of every Gray step.
- The wrap from the last Gray code back to zero.

Some behaviour only the bench's scenarios can show. These are the exact Gray order, and the jump from a code reached in one mode into the other sequence for every code under both mode values. They also include the reset that lands in the middle of a Gray run, and the stated 0,0,1,1 mode sequence. A behavioural model in the bench predicts the count on every clock.

// File: rtl/mcnt_pkg.sv
package mcnt_pkg;
  typedef enum logic {
    SEQ_BINARY = 1'b0,
    SEQ_GRAY   = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/mcnt_bin_step.sv
module mcnt_bin_step #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur_code,
  output logic [WIDTH-1:0] nxt_code
);
  // Natural binary successor; overflow drops out of the sum and wraps to zero.
  always_comb begin
    nxt_code = cur_code + {{(WIDTH-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/mcnt_gray_step.sv
module mcnt_gray_step #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur_code,
  output logic [WIDTH-1:0] nxt_code
);
  logic [WIDTH-1:0] rank;
  logic [WIDTH-1:0] rank_inc;

  // Recover the position of the code in the reflected sequence.
  assign rank[WIDTH-1] = cur_code[WIDTH-1];
  generate
    for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_rank
      assign rank[i] = rank[i+1] ^ cur_code[i];
    end
  endgenerate

  // Step the position, then re-express it as a reflected code.
  always_comb begin
    rank_inc = rank + {{(WIDTH-1){1'b0}}, 1'b1};
    nxt_code = rank_inc ^ (rank_inc >> 1);
  end
endmodule

// File: rtl/mcnt_step_sel.sv
module mcnt_step_sel
  import mcnt_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur_code,
  input  logic             mode_gray,
  output logic [WIDTH-1:0] nxt_code
);
  logic [WIDTH-1:0] bin_nxt;
  logic [WIDTH-1:0] gray_nxt;
  seq_mode_e        sel;

  mcnt_bin_step #(.WIDTH(WIDTH)) bin_i (
    .cur_code (cur_code),
    .nxt_code (bin_nxt)
  );

  mcnt_gray_step #(.WIDTH(WIDTH)) gray_i (
    .cur_code (cur_code),
    .nxt_code (gray_nxt)
  );

  assign sel = seq_mode_e'(mode_gray);

  always_comb begin
    case (sel)
      SEQ_BINARY: nxt_code = bin_nxt;
      SEQ_GRAY:   nxt_code = gray_nxt;
      default:    nxt_code = bin_nxt;
    endcase
  end
endmodule

// File: rtl/modal_counter.sv
module modal_counter #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_gray,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  mcnt_step_sel #(.WIDTH(WIDTH)) step_i (
    .cur_code  (state_q),
    .mode_gray (mode_gray),
    .nxt_code  (state_d)
  );

  // Reset wins over the step taken in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) state_q <= '0;
    else     state_q <= state_d;
  end

  assign count = state_q;
endmodule

// File: rtl/modal_counter_chk.sv
module modal_counter_chk #(
  parameter int WIDTH = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_gray,
  input logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] GRAY_LAST = {1'b1, {(WIDTH-1){1'b0}}};

  logic armed_q = 1'b0;
  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) begin
    armed_q    <= 1'b1;
    rst_seen_q <= rst;
    // R1
    if (armed_q && rst_seen_q) begin
      reset_clear_chk: assert (count == '0)
        else $error("reset did not clear count");
    end
  end

  // R2
  bin_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_gray) |=> (count == WIDTH'($past(count) + 1'b1)));

  // R5
  gray_one_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_gray) |=> ($countones(count ^ $past(count)) == 1));

  // R3
  gray_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_gray && count == GRAY_LAST) |=> (count == '0));
endmodule

bind modal_counter modal_counter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode_gray (mode_gray),
  .count     (count)
);

// File: tb/modal_counter_tb_top.sv
`timescale 1ns/1ps
module modal_counter_tb_top;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_gray = 1'b0;
  logic [W-1:0] count;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_cnt  = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  modal_counter #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .mode_gray (mode_gray),
    .count     (count)
  );

  // Behavioural reference: the Gray order is held as a list, the binary order as integers.
  int gray_list[$] = '{0, 1, 3, 2, 6, 7, 5, 4};

  function automatic int model_next(int cur, bit r, bit m);
    if (r) return 0;
    if (!m) return (cur + 1) % 8;
    foreach (gray_list[k]) begin
      if (gray_list[k] == cur) return gray_list[(k + 1) % 8];
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick(bit r, bit m, string req);
    int prev;
    prev = int'(count);
    rst = r;
    mode_gray = m;
    exp_cnt = model_next(exp_cnt, r, m);
    @(posedge clk);
    #1;
    check(int'(count) == exp_cnt, req, int'(count), exp_cnt);
    if (!r && m)
      check($countones(W'(prev) ^ count) == 1, "R5", int'(count), exp_cnt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: count=%0d expected=%0d", count, exp_cnt);
    finish_run();
  end

  initial begin
    // R1 reset state, in both mode values
    tick(1, 0, "R1");
    tick(1, 1, "R1");

    // R6 stated sequence 0,0,1,1
    tick(0, 0, "R6");
    tick(0, 0, "R6");
    tick(0, 1, "R6");
    tick(0, 1, "R6");

    // R1 reset beats counting mid Gray run
    tick(0, 1, "R3");
    tick(1, 1, "R1");

    // R2 full binary run with wrap
    for (int i = 0; i < 10; i++) tick(0, 0, "R2");
    tick(1, 0, "R1");

    // R3 full Gray run with wrap 100 -> 000
    for (int i = 0; i < 10; i++) tick(0, 1, "R3");

    // R4 every code under both mode values, reached in binary order
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 2; m++) begin
        tick(1, 0, "R1");
        for (int k = 0; k < s; k++) tick(0, 0, "R2");
        tick(0, bit'(m), "R4");
      end
    end

    // R4 alternating modes
    tick(1, 0, "R1");
    for (int i = 0; i < 24; i++) tick(0, bit'(i % 2), "R4");
    for (int i = 0; i < 24; i++) tick(0, bit'((i / 3) % 2), "R4");

    finish_run();
  end
endmodule